// File: doc/BRIEF.md
# Byte-Lane Register Dependency Scoreboard

This block is the register-side dependency matrix of an out-of-order core's scoreboard. Each row belongs to one function unit. Each column belongs to one byte lane of one 64-bit architectural register, so a register owns eight columns. Narrow operations therefore reserve only the bytes they actually touch. An 8-bit write into the low byte of a register leaves the other seven bytes free for other writers and readers.

At issue, a unit hands over three things: one destination register with an 8-bit write mask, and two source registers, each with an 8-bit read mask. A mask of zero means that operand is unused. The block refuses the issue if the unit is still occupied, or if any requested destination byte already has an outstanding writer. Once the block accepts an issue, it keeps the unit's write and read lanes until the unit signals completion.

The block drives two outputs, and both depend only on its stored state:
- a per-lane vector that shows which register bytes still await a write;
- a per-unit read-hazard flag that is high while any byte the unit reads awaits a write from some other unit.

Decode, operand fetch and the register storage live elsewhere.

Top module: `bytedep_matrix`

## Requirements
- R1: After a cycle with `rst` high, `lane_pending` is all zero, `rd_hazard` is all zero, and every unit is free to issue.
- R2: An accepted issue sets `lane_pending` bit `reg*8+b` for every bit b set in the write mask. The bits are visible from the clock edge that accepts the issue. Lane index `reg*8+b` is byte b (bit 0 = least significant byte) of register `reg`.
- R3: `issue_ready` is low when any requested destination byte is already pending. A refused issue leaves `lane_pending` and `rd_hazard` unchanged.
- R4: Two units may hold byte-disjoint writes to the same register at the same time. Each issue is accepted, and only the requested lanes become pending.
- R5: `issue_ready` is low when the addressed unit has been accepted and has not yet completed. It is also low when `issue_valid` is low, or when `issue_fu` is not below the unit count.
- R6: `rd_hazard[f]` is high exactly when some lane that unit f reads is pending by a different unit. Pending lanes that f does not read do not raise it, and lanes that f itself writes do not raise it either.
- R7: When `done[f]` is high at an edge, unit f's write lanes and read record are cleared at that edge. Hazards that depended on f drop at the same edge.
- R8: Several `done` bits high in one cycle clear all of the named units at the same edge.
- R9: Cycles with `issue_valid` low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request |
| issue_fu | input | $clog2(NUM_FU) | Unit receiving the operation |
| issue_dst | input | $clog2(NUM_REGS) | Destination register |
| issue_dst_mask | input | 8 | Destination bytes written |
| issue_src_a | input | $clog2(NUM_REGS) | First source register |
| issue_src_a_mask | input | 8 | Bytes read from first source |
| issue_src_b | input | $clog2(NUM_REGS) | Second source register |
| issue_src_b_mask | input | 8 | Bytes read from second source |
| issue_ready | output | 1 | Issue accepted this cycle |
| done | input | NUM_FU | Per-unit write-back complete |
| lane_pending | output | NUM_REGS*8 | Per register byte: a write is outstanding |
| rd_hazard | output | NUM_FU | Per unit: a read byte awaits another unit |

## Verification
The bench sweeps every combination of register, written byte and read byte for one writer and one reader. This shows that a hazard appears only on an exact byte match, and never from a neighbouring byte of the same register. Directed patterns then split one register between two byte-disjoint writers. They attempt an overlapping write and an issue to an occupied unit, and retire writers one at a time and together. These patterns separate lane-exact clearing from whole-register clearing. A write whose destination bytes overlap its own source bytes shows that a unit never blocks itself.

// File: rtl/bytedep_pkg.sv
package bytedep_pkg;
  localparam int LANES = 8;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/bytedep_lane_decode.sv
module bytedep_lane_decode
  import bytedep_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS),
  localparam int COLS    = NUM_REGS * LANES
) (
  input  logic [REG_W-1:0] idx,
  input  lane_mask_t       mask,
  output logic [COLS-1:0]  lanes
);
  // Place the byte mask into the eight columns of the selected register.
  always_comb begin
    lanes = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (idx == REG_W'(r)) lanes[r*LANES +: LANES] = mask;
    end
  end
endmodule

// File: rtl/bytedep_row.sv
module bytedep_row #(
  parameter int COLS = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            clear,
  input  logic [COLS-1:0] wr_in,
  input  logic [COLS-1:0] rd_in,
  output logic [COLS-1:0] wr_q,
  output logic [COLS-1:0] rd_q,
  output logic            busy_q
);
  // A load only happens on an idle unit, so it never meets a useful clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      wr_q   <= wr_in;
      rd_q   <= rd_in;
      busy_q <= 1'b1;
    end else if (clear) begin
      wr_q   <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bytedep_hazard.sv
module bytedep_hazard #(
  parameter int NUM_FU = 4,
  parameter int COLS   = 256
) (
  input  logic [NUM_FU-1:0][COLS-1:0] wr_rows,
  input  logic [NUM_FU-1:0][COLS-1:0] rd_rows,
  output logic [COLS-1:0]             pending,
  output logic [NUM_FU-1:0]           hazard
);
  // Column OR: a lane is pending when any unit will write it.
  always_comb begin
    pending = '0;
    for (int f = 0; f < NUM_FU; f++) pending |= wr_rows[f];
  end

  // Writers never share a lane, so removing a unit's own row from the
  // column OR leaves exactly the lanes owned by the other units.
  for (genvar f = 0; f < NUM_FU; f++) begin : g_hz
    assign hazard[f] = |(rd_rows[f] & pending & ~wr_rows[f]);
  end
endmodule

// File: rtl/bytedep_matrix.sv
module bytedep_matrix
  import bytedep_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 32,
  localparam int FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int COLS    = NUM_REGS * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [FU_W-1:0]   issue_fu,
  input  logic [REG_W-1:0]  issue_dst,
  input  logic [7:0]        issue_dst_mask,
  input  logic [REG_W-1:0]  issue_src_a,
  input  logic [7:0]        issue_src_a_mask,
  input  logic [REG_W-1:0]  issue_src_b,
  input  logic [7:0]        issue_src_b_mask,
  output logic              issue_ready,
  input  logic [NUM_FU-1:0] done,
  output logic [COLS-1:0]   lane_pending,
  output logic [NUM_FU-1:0] rd_hazard
);
  logic [COLS-1:0]             dst_lanes, srca_lanes, srcb_lanes;
  logic [NUM_FU-1:0][COLS-1:0] wr_rows, rd_rows;
  logic [NUM_FU-1:0]           busy;
  logic                        fu_hit, fu_busy;

  bytedep_lane_decode #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dec_dst (
    .idx(issue_dst), .mask(issue_dst_mask), .lanes(dst_lanes));
  bytedep_lane_decode #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dec_sa (
    .idx(issue_src_a), .mask(issue_src_a_mask), .lanes(srca_lanes));
  bytedep_lane_decode #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_dec_sb (
    .idx(issue_src_b), .mask(issue_src_b_mask), .lanes(srcb_lanes));

  // Target unit lookup without indexing past the unit count.
  always_comb begin
    fu_hit  = 1'b0;
    fu_busy = 1'b0;
    for (int f = 0; f < NUM_FU; f++) begin
      if (issue_fu == FU_W'(f)) begin
        fu_hit  = 1'b1;
        fu_busy = busy[f];
      end
    end
  end

  assign issue_ready = issue_valid && fu_hit && !fu_busy &&
                       !(|(dst_lanes & lane_pending));

  for (genvar f = 0; f < NUM_FU; f++) begin : g_row
    bytedep_row #(.COLS(COLS)) u_row (
      .clk   (clk),
      .rst   (rst),
      .load  (issue_ready && (issue_fu == FU_W'(f))),
      .clear (done[f]),
      .wr_in (dst_lanes),
      .rd_in (srca_lanes | srcb_lanes),
      .wr_q  (wr_rows[f]),
      .rd_q  (rd_rows[f]),
      .busy_q(busy[f])
    );
  end

  bytedep_hazard #(.NUM_FU(NUM_FU), .COLS(COLS)) u_hz (
    .wr_rows(wr_rows),
    .rd_rows(rd_rows),
    .pending(lane_pending),
    .hazard (rd_hazard)
  );
endmodule

// File: rtl/bytedep_matrix_chk.sv
module bytedep_matrix_chk #(
  parameter int NUM_FU = 4,
  parameter int COLS   = 256,
  parameter int FU_W   = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        issue_valid,
  input logic                        issue_ready,
  input logic [FU_W-1:0]             issue_fu,
  input logic [NUM_FU-1:0]           done,
  input logic [COLS-1:0]             dst_lanes,
  input logic [COLS-1:0]             lane_pending,
  input logic [NUM_FU-1:0]           rd_hazard,
  input logic [NUM_FU-1:0][COLS-1:0] wr_rows
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lane_pending == '0 && rd_hazard == '0));

  assert_issue_sets_R2: assert property (@(posedge clk) disable iff (rst)
    issue_ready |=> ((lane_pending & $past(dst_lanes)) == $past(dst_lanes)));

  assert_refuse_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready && done == '0) |=>
      ($stable(lane_pending) && $stable(rd_hazard)));

  assert_ready_valid_R5: assert property (@(posedge clk) disable iff (rst)
    issue_ready |-> issue_valid);

  assert_no_pending_no_hazard_R6: assert property (@(posedge clk) disable iff (rst)
    (lane_pending == '0) |-> (rd_hazard == '0));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!issue_valid && done == '0) |=> $stable(lane_pending));

  for (genvar f = 0; f < NUM_FU; f++) begin : g_done
    assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (done[f] && !(issue_ready && issue_fu == FU_W'(f))) |=> (wr_rows[f] == '0));
  end
endmodule

bind bytedep_matrix bytedep_matrix_chk #(
  .NUM_FU(NUM_FU), .COLS(COLS), .FU_W(FU_W)
) u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
  .issue_fu(issue_fu), .done(done), .dst_lanes(dst_lanes),
  .lane_pending(lane_pending), .rd_hazard(rd_hazard), .wr_rows(wr_rows)
);

// File: tb/bytedep_matrix_tb.sv
`timescale 1ns/1ps
module bytedep_matrix_tb;
  localparam int NF   = 4;
  localparam int NR   = 4;
  localparam int COLS = NR * 8;

  logic clk = 1'b0;
  logic rst;
  logic issue_valid;
  logic [1:0] issue_fu, issue_dst, issue_src_a, issue_src_b;
  logic [7:0] issue_dst_mask, issue_src_a_mask, issue_src_b_mask;
  logic issue_ready;
  logic [NF-1:0] done;
  logic [COLS-1:0] lane_pending;
  logic [NF-1:0] rd_hazard;

  int checks = 0;
  int errors = 0;

  logic [COLS-1:0] m_wr [NF];
  logic [COLS-1:0] m_rd [NF];
  bit              m_busy [NF];

  always #5 clk = ~clk;

  bytedep_matrix #(.NUM_FU(NF), .NUM_REGS(NR)) u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_fu(issue_fu),
    .issue_dst(issue_dst), .issue_dst_mask(issue_dst_mask),
    .issue_src_a(issue_src_a), .issue_src_a_mask(issue_src_a_mask),
    .issue_src_b(issue_src_b), .issue_src_b_mask(issue_src_b_mask),
    .issue_ready(issue_ready), .done(done),
    .lane_pending(lane_pending), .rd_hazard(rd_hazard));

  function automatic logic [COLS-1:0] lanes_of(int r, logic [7:0] m);
    return {{(COLS-8){1'b0}}, m} << (r * 8);
  endfunction

  function automatic logic [COLS-1:0] exp_pending();
    logic [COLS-1:0] p = '0;
    for (int f = 0; f < NF; f++) p |= m_wr[f];
    return p;
  endfunction

  function automatic logic [NF-1:0] exp_hazard();
    logic [NF-1:0] h = '0;
    for (int f = 0; f < NF; f++) begin
      logic [COLS-1:0] oth = '0;
      for (int g = 0; g < NF; g++) if (g != f) oth |= m_wr[g];
      h[f] = |(m_rd[f] & oth);
    end
    return h;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, 64'(lane_pending), 64'(exp_pending()));
    chk(req, 64'(rd_hazard), 64'(exp_hazard()));
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic issue(string req, int fu, int d, logic [7:0] dm,
                       int a, logic [7:0] am, int b, logic [7:0] bm);
    logic exp_ok;
    issue_valid = 1'b1; issue_fu = 2'(fu);
    issue_dst = 2'(d); issue_dst_mask = dm;
    issue_src_a = 2'(a); issue_src_a_mask = am;
    issue_src_b = 2'(b); issue_src_b_mask = bm;
    exp_ok = !m_busy[fu] && !(|(lanes_of(d, dm) & exp_pending()));
    #1;
    chk(req, 64'(issue_ready), 64'(exp_ok));
    @(posedge clk);
    if (exp_ok) begin
      m_wr[fu] = lanes_of(d, dm);
      m_rd[fu] = lanes_of(a, am) | lanes_of(b, bm);
      m_busy[fu] = 1'b1;
    end
    @(negedge clk);
    issue_valid = 1'b0;
    check_state(req);
  endtask

  task automatic retire(string req, logic [NF-1:0] v);
    done = v;
    @(posedge clk);
    for (int f = 0; f < NF; f++) if (v[f]) begin
      m_wr[f] = '0; m_rd[f] = '0; m_busy[f] = 1'b0;
    end
    @(negedge clk);
    done = '0;
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; issue_valid = 1'b0; issue_fu = '0; issue_dst = '0;
    issue_dst_mask = '0; issue_src_a = '0; issue_src_a_mask = '0;
    issue_src_b = '0; issue_src_b_mask = '0; done = '0;
    for (int f = 0; f < NF; f++) begin m_wr[f] = '0; m_rd[f] = '0; m_busy[f] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_state("R1");

    // R6 sweep: one-byte writer (fu0) versus one-byte reader (fu1).
    for (int r = 0; r < NR; r++)
      for (int wb = 0; wb < 8; wb++)
        for (int rb = 0; rb < 8; rb++) begin
          issue("R2", 0, r, 8'(1 << wb), 0, 8'h00, 0, 8'h00);
          issue("R6", 1, (r + 1) % NR, 8'h00, r, 8'(1 << rb), 0, 8'h00);
          chk("R6", 64'(rd_hazard[1]), 64'(wb == rb));
          retire("R7", 4'b0011);
        end

    // R4: byte-disjoint writers share register 2.
    issue("R4", 0, 2, 8'h0F, 0, 8'h00, 0, 8'h00);
    issue("R4", 1, 2, 8'hF0, 0, 8'h00, 0, 8'h00);
    chk("R4", 64'(lane_pending), 64'(32'h00FF_0000));
    // R3: overlapping write refused.
    issue("R3", 2, 2, 8'h10, 0, 8'h00, 0, 8'h00);
    // R5: occupied unit refused.
    issue("R5", 1, 3, 8'h01, 0, 8'h00, 0, 8'h00);
    // R9: idle cycles change nothing.
    @(negedge clk); @(negedge clk);
    check_state("R9");
    // Readers stall on both halves.
    issue("R6", 2, 3, 8'h02, 2, 8'h01, 0, 8'h00);
    issue("R6", 3, 0, 8'h00, 1, 8'hFF, 2, 8'h80);
    chk("R6", 64'(rd_hazard), 64'(4'b1100));
    // R7: fu0 completes; only fu2's stall clears.
    retire("R7", 4'b0001);
    chk("R7", 64'(rd_hazard), 64'(4'b1000));
    // R8: retire remaining units together.
    retire("R8", 4'b1110);
    chk("R8", 64'(lane_pending), 64'(0));
    // R6: a unit reading its own destination bytes is not blocked.
    issue("R6", 0, 1, 8'h01, 1, 8'h01, 1, 8'h02);
    chk("R6", 64'(rd_hazard[0]), 64'(0));
    retire("R7", 4'b0001);
    // R1: reset in mid-flight.
    issue("R2", 3, 0, 8'hAA, 0, 8'h00, 0, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int f = 0; f < NF; f++) begin m_wr[f] = '0; m_rd[f] = '0; m_busy[f] = 0; end
    check_state("R1");
    issue("R1", 3, 0, 8'hAA, 0, 8'h00, 0, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule